// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory instruction issued by a whole warp and turns it into a short series of cache-line requests. Each lane supplies an address. An active-lane mask says which lanes take part. The instruction also carries an access size in bytes, a write flag and an address-space code. The space code selects the line size for the access: the texture space uses one line size and the constant/parameter space uses another. Both sizes are set by parameters.

Once the instruction is accepted, the block groups the active lanes whose addresses fall in the same aligned line. It then emits one request for each distinct line, on a valid/ready output. A request carries the line address, the line size, the write flag, the mask of lanes that map to that line, and a byte mask. The byte mask is gathered once over all active lanes, and the same mask goes out with every request of the instruction. Requests leave in ascending line-address order, at most one per cycle. A one-cycle done pulse marks the end of the instruction, and after it the block accepts the next one.

Top module: `warp_coalescer`

## Requirements
- R1: `start_ready` is high only when the block is idle: it is high after reset, low while requests of an accepted instruction are outstanding, and never high in the same cycle as `req_valid` or `done`.
- R2: The line address of a lane is its address with the low log2(line size) bits cleared. Space code 1 uses `TEX_LINE_B` bytes (default 128), and space code 2 uses `CONST_LINE_B` bytes (default 64). Codes 0 and 3 have a line size of zero and produce no requests.
- R3: Exactly one request is emitted for each distinct line address among the active lanes. In its lane mask, bit i is set exactly when lane i is active and maps to that line.
- R4: An inactive lane contributes no request, no lane-mask bit and no byte-mask bit, whatever its address.
- R5: Within one instruction, requests are emitted in strictly increasing line-address order.
- R6: The byte mask is the union, over all active lanes, of bits offset through offset+size-1, where offset is the lane address minus its line address. Bit b stands for byte b of the line, and bits at or above the line size are dropped. The same mask is attached to every request of the instruction.
- R7: `req_line_bytes` carries the selected line size in bytes, and `req_write` carries the write flag of the accepted instruction.
- R8: While `req_valid` is high and `req_ready` is low, the request stays valid and all its fields hold steady.
- R9: `done` is high for exactly one cycle, in the cycle after the handshake of the last request, and `start_ready` is high in the cycle after `done`.
- R10: An instruction that produces no requests (all lanes inactive, or a zero line size) raises `done` in the cycle right after it is accepted, and `req_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | A warp instruction is offered |
| start_ready | output | 1 | Block is idle and takes the instruction |
| start_addr | input | LANES*ADDR_W | Lane i address at bits [i*ADDR_W +: ADDR_W] |
| start_active | input | LANES | Active-lane mask |
| start_size | input | SIZE_W | Access size in bytes per lane |
| start_write | input | 1 | Instruction is a store |
| start_space | input | 2 | Space code: 1 texture, 2 constant/parameter, 0 and 3 uncached |
| req_valid | output | 1 | A line request is presented |
| req_ready | input | 1 | Consumer takes the request |
| req_line_addr | output | ADDR_W | Aligned line address |
| req_line_bytes | output | LB_W | Line size in bytes |
| req_write | output | 1 | Write flag of the instruction |
| req_lanes | output | LANES | Lanes mapping to this line |
| req_byte_mask | output | MAX_LINE_B | Byte mask accumulated over all active lanes |
| done | output | 1 | One-cycle pulse at the end of the instruction |

## Verification
The assertions assume two things about the inputs. First, `TEX_LINE_B` and `CONST_LINE_B` are powers of two, no larger than `MAX_LINE_B`, so that cleared low bits give an aligned line. Second, the consumer keeps sampling `req_ready` each cycle and never relies on a combinational path from ready to valid. The stimulus sticks to power-of-two access sizes from 1 to 16 bytes and to the default line sizes. It also drives `req_ready` at random so that stalls occur in the middle of a sequence. Lanes that cross the end of a line appear only in a directed case, where the dropped bits are part of the expected mask.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_FIN  = 2'd2
    } coal_state_e;

    localparam logic [1:0] SPACE_TEX   = 2'd1;
    localparam logic [1:0] SPACE_CONST = 2'd2;
endpackage

// File: rtl/coal_line_size.sv
module coal_line_size #(
    parameter int TEX_LINE_B   = 128,
    parameter int CONST_LINE_B = 64,
    parameter int LB_W         = 9
) (
    input  logic [1:0]      space,
    output logic [LB_W-1:0] line_bytes
);
    import coal_pkg::*;

    always_comb begin
        unique case (space)
            SPACE_TEX:   line_bytes = LB_W'(TEX_LINE_B);
            SPACE_CONST: line_bytes = LB_W'(CONST_LINE_B);
            default:     line_bytes = '0;
        endcase
    end
endmodule

// File: rtl/coal_byte_acc.sv
module coal_byte_acc #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 5,
    parameter int MAX_LINE_B = 256,
    parameter int LB_W       = 9
) (
    input  logic [LANES-1:0][ADDR_W-1:0] addrs,
    input  logic [LANES-1:0]             active,
    input  logic [SIZE_W-1:0]            size,
    input  logic [LB_W-1:0]              line_bytes,
    output logic [MAX_LINE_B-1:0]        mask
);
    localparam int MW  = MAX_LINE_B;
    localparam int MWP = MAX_LINE_B + 1;

    logic [MWP-1:0]    lim_wide;
    logic [MW-1:0]     run;
    logic [MW-1:0]     acc;
    logic [ADDR_W-1:0] off_mask;

    always_comb begin
        lim_wide = (MWP'(1) << line_bytes) - MWP'(1);
        run      = (MW'(1) << size) - MW'(1);
        off_mask = ADDR_W'(line_bytes) - ADDR_W'(1);
        acc      = '0;
        for (int i = 0; i < LANES; i++) begin
            if (active[i]) begin
                acc = acc | (run << (addrs[i] & off_mask));
            end
        end
        mask = acc & lim_wide[MW-1:0];
    end
endmodule

// File: rtl/coal_min_pick.sv
module coal_min_pick #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input  logic [LANES-1:0]             pending,
    input  logic [LANES-1:0][ADDR_W-1:0] lines,
    output logic [ADDR_W-1:0]            min_line,
    output logic [LANES-1:0]             hit_mask
);
    logic found;

    always_comb begin
        found    = 1'b0;
        min_line = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pending[i] && (!found || lines[i] < min_line)) begin
                min_line = lines[i];
                found    = 1'b1;
            end
        end
        for (int i = 0; i < LANES; i++) begin
            hit_mask[i] = pending[i] && (lines[i] == min_line);
        end
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int LANES        = 32,
    parameter int ADDR_W       = 32,
    parameter int SIZE_W       = 5,
    parameter int TEX_LINE_B   = 128,
    parameter int CONST_LINE_B = 64,
    parameter int MAX_LINE_B   = 256,
    parameter int LB_W         = $clog2(MAX_LINE_B) + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_valid,
    output logic                      start_ready,
    input  logic [LANES*ADDR_W-1:0]   start_addr,
    input  logic [LANES-1:0]          start_active,
    input  logic [SIZE_W-1:0]         start_size,
    input  logic                      start_write,
    input  logic [1:0]                start_space,
    output logic                      req_valid,
    input  logic                      req_ready,
    output logic [ADDR_W-1:0]         req_line_addr,
    output logic [LB_W-1:0]           req_line_bytes,
    output logic                      req_write,
    output logic [LANES-1:0]          req_lanes,
    output logic [MAX_LINE_B-1:0]     req_byte_mask,
    output logic                      done
);
    import coal_pkg::*;

    typedef struct packed {
        coal_state_e                  state;
        logic [LANES-1:0]             pending;
        logic [LANES-1:0][ADDR_W-1:0] lines;
        logic [LB_W-1:0]              line_b;
        logic                         write;
        logic [MAX_LINE_B-1:0]        bmask;
    } coal_regs_t;

    coal_regs_t q, d;

    logic [LANES-1:0][ADDR_W-1:0] lane_addr;
    logic [LANES-1:0][ADDR_W-1:0] cap_lines;
    logic [LB_W-1:0]              in_line_b;
    logic [ADDR_W-1:0]            in_lo_mask;
    logic [MAX_LINE_B-1:0]        in_bmask;
    logic [ADDR_W-1:0]            pick_line;
    logic [LANES-1:0]             pick_hits;
    logic [LANES-1:0]             left_after;

    assign lane_addr  = start_addr;
    assign in_lo_mask = ADDR_W'(in_line_b) - ADDR_W'(1);

    coal_line_size #(
        .TEX_LINE_B   (TEX_LINE_B),
        .CONST_LINE_B (CONST_LINE_B),
        .LB_W         (LB_W)
    ) u_size (
        .space      (start_space),
        .line_bytes (in_line_b)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_cap
            assign cap_lines[g] = lane_addr[g] & ~in_lo_mask;
        end
    endgenerate

    coal_byte_acc #(
        .LANES      (LANES),
        .ADDR_W     (ADDR_W),
        .SIZE_W     (SIZE_W),
        .MAX_LINE_B (MAX_LINE_B),
        .LB_W       (LB_W)
    ) u_bytes (
        .addrs      (lane_addr),
        .active     (start_active),
        .size       (start_size),
        .line_bytes (in_line_b),
        .mask       (in_bmask)
    );

    coal_min_pick #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W)
    ) u_pick (
        .pending  (q.pending),
        .lines    (q.lines),
        .min_line (pick_line),
        .hit_mask (pick_hits)
    );

    assign left_after = q.pending & ~pick_hits;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (start_valid) begin
                    d.lines   = cap_lines;
                    d.line_b  = in_line_b;
                    d.write   = start_write;
                    d.bmask   = in_bmask;
                    d.pending = (in_line_b != '0) ? start_active : '0;
                    d.state   = ((in_line_b != '0) && (start_active != '0)) ? ST_EMIT : ST_FIN;
                end
            end
            ST_EMIT: begin
                if (req_ready) begin
                    d.pending = left_after;
                    if (left_after == '0) begin
                        d.state = ST_FIN;
                    end
                end
            end
            ST_FIN: begin
                d.state = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign start_ready    = (q.state == ST_IDLE);
    assign req_valid      = (q.state == ST_EMIT);
    assign req_line_addr  = pick_line;
    assign req_line_bytes = q.line_b;
    assign req_write      = q.write;
    assign req_lanes      = pick_hits;
    assign req_byte_mask  = q.bmask;
    assign done           = (q.state == ST_FIN);

    // R1: no new instruction while requests are outstanding
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> (!req_valid && !done));

    // R2: emitted line address is aligned to the line size
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_line_addr & (ADDR_W'(req_line_bytes) - ADDR_W'(1))) == '0));

    // R3: each request covers at least one lane
    p_lanes_nz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_lanes != '0));

    // R4: lanes of a request are drawn only from lanes still awaiting service
    p_lanes_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_lanes & ~q.pending) == '0));

    // R5: strictly ascending line addresses
    p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_valid || (req_line_addr > $past(req_line_addr))));

    // R6: byte mask identical across requests of one instruction
    p_bmask_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_valid || $stable(req_byte_mask)));

    // R8: stalled request holds
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_line_addr)
            && $stable(req_lanes) && $stable(req_byte_mask)));

    // R9: done is a single pulse followed by idle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (start_ready && !done));
endmodule

// File: tb/tb_warp_coalescer.sv
module tb_warp_coalescer;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 32;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 5;
    localparam int TEXB   = 128;
    localparam int CONSTB = 64;
    localparam int MAXB   = 256;
    localparam int LB_W   = $clog2(MAXB) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_valid = 1'b0;
    logic start_ready;
    logic [LANES*ADDR_W-1:0] start_addr = '0;
    logic [LANES-1:0] start_active = '0;
    logic [SIZE_W-1:0] start_size = '0;
    logic start_write = 1'b0;
    logic [1:0] start_space = '0;
    logic req_valid;
    logic req_ready = 1'b0;
    logic [ADDR_W-1:0] req_line_addr;
    logic [LB_W-1:0] req_line_bytes;
    logic req_write;
    logic [LANES-1:0] req_lanes;
    logic [MAXB-1:0] req_byte_mask;
    logic done;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_coalescer #(
        .LANES(LANES), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
        .TEX_LINE_B(TEXB), .CONST_LINE_B(CONSTB), .MAX_LINE_B(MAXB)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_addr(start_addr), .start_active(start_active),
        .start_size(start_size), .start_write(start_write),
        .start_space(start_space),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_line_addr(req_line_addr), .req_line_bytes(req_line_bytes),
        .req_write(req_write), .req_lanes(req_lanes),
        .req_byte_mask(req_byte_mask), .done(done)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    logic [ADDR_W-1:0] ta [LANES];
    logic [LANES-1:0]  tact;
    int                tsize;
    bit                twr;
    logic [1:0]        tsp;

    logic [ADDR_W-1:0] e_line [LANES];
    logic [LANES-1:0]  e_lanes [LANES];
    logic [MAXB-1:0]   e_bm;
    int                e_n;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [MAXB-1:0] act, input logic [MAXB-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int line_of(input logic [1:0] sp);
        if (sp == 2'd1) return TEXB;
        if (sp == 2'd2) return CONSTB;
        return 0;
    endfunction

    task automatic build_expected();
        int lb;
        logic [ADDR_W-1:0] la;
        bit seen;
        lb = line_of(tsp);
        e_n = 0;
        e_bm = '0;
        if (lb == 0) return;
        for (int i = 0; i < LANES; i++) begin
            if (!tact[i]) continue;
            la = ta[i] - (ta[i] % ADDR_W'(lb));
            for (int b = 0; b < tsize; b++) begin
                int idx;
                idx = int'(ta[i] - la) + b;
                if (idx < lb) e_bm[idx] = 1'b1;
            end
            seen = 1'b0;
            for (int k = 0; k < e_n; k++) begin
                if (e_line[k] == la) begin
                    e_lanes[k][i] = 1'b1;
                    seen = 1'b1;
                end
            end
            if (!seen) begin
                e_line[e_n] = la;
                e_lanes[e_n] = '0;
                e_lanes[e_n][i] = 1'b1;
                e_n++;
            end
        end
        for (int a = 1; a < e_n; a++) begin
            for (int b = a; b > 0 && e_line[b] < e_line[b-1]; b--) begin
                logic [ADDR_W-1:0] tl;
                logic [LANES-1:0]  tm;
                tl = e_line[b]; e_line[b] = e_line[b-1]; e_line[b-1] = tl;
                tm = e_lanes[b]; e_lanes[b] = e_lanes[b-1]; e_lanes[b-1] = tm;
            end
        end
    endtask

    task automatic run_instr(input int ready_pct);
        int k;
        int waited;
        bit hs;
        bit last_hs;
        bit stalled;
        bit fin;
        build_expected();
        waited = 0;
        @(negedge clk);
        while (!start_ready && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        for (int i = 0; i < LANES; i++) start_addr[i*ADDR_W +: ADDR_W] = ta[i];
        start_active = tact;
        start_size   = SIZE_W'(tsize);
        start_write  = twr;
        start_space  = tsp;
        start_valid  = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        chk(!start_ready, "R1", "start_ready low after accept", MAXB'(start_ready), '0);
        k = 0; hs = 0; last_hs = 0; stalled = 0; fin = 0;
        for (int c = 0; c < 4000 && !fin; c++) begin
            if (done) begin
                chk(k == e_n, "R3", "request count", MAXB'(k), MAXB'(e_n));
                if (e_n == 0) begin
                    chk(c == 0, "R10", "done right after accept", MAXB'(c), '0);
                end else begin
                    chk(last_hs, "R9", "done after last handshake", MAXB'(last_hs), MAXB'(1));
                end
                fin = 1;
            end else begin
                if (stalled) begin
                    chk(req_valid, "R8", "valid held during stall", MAXB'(req_valid), MAXB'(1));
                end
                hs = 0;
                stalled = 0;
                if (req_valid) begin
                    if (k >= e_n) begin
                        chk(0, "R3", "extra request", MAXB'(k), MAXB'(e_n));
                    end else begin
                        chk(req_line_addr == e_line[k], "R5", "line address order",
                            MAXB'(req_line_addr), MAXB'(e_line[k]));
                        chk(req_lanes == e_lanes[k], "R3", "lane mask",
                            MAXB'(req_lanes), MAXB'(e_lanes[k]));
                        chk(req_byte_mask == e_bm, "R6", "byte mask", req_byte_mask, e_bm);
                        chk(req_line_bytes == LB_W'(line_of(tsp)) && req_write == twr,
                            "R7", "line bytes/write", MAXB'({req_line_bytes, req_write}),
                            MAXB'({LB_W'(line_of(tsp)), twr}));
                    end
                    req_ready = (($urandom % 100) < ready_pct);
                    hs = req_ready;
                    stalled = !req_ready;
                end else begin
                    req_ready = (($urandom % 100) < ready_pct);
                end
                last_hs = hs;
                @(negedge clk);
                if (hs) k++;
            end
        end
        if (!fin) chk(0, "R9", "done never seen", '0, MAXB'(1));
        @(negedge clk);
        chk(start_ready && !done, "R9", "idle after done",
            MAXB'({start_ready, done}), MAXB'(2));
    endtask

    task automatic gen_random();
        int mode;
        int sz_log;
        logic [ADDR_W-1:0] base;
        mode   = $urandom % 3;
        sz_log = $urandom % 5;
        tsize  = 1 << sz_log;
        tsp    = (($urandom % 8) == 0) ? 2'(($urandom % 2) * 3) : 2'(1 + ($urandom % 2));
        twr    = $urandom % 2;
        tact   = (($urandom % 4) == 0) ? '1 : LANES'($urandom);
        base   = ADDR_W'($urandom) & ~ADDR_W'(32'hFFF);
        for (int i = 0; i < LANES; i++) begin
            logic [ADDR_W-1:0] off;
            off = ADDR_W'($urandom % 256) & ~ADDR_W'(tsize - 1);
            case (mode)
                0: ta[i] = base + ADDR_W'(i * tsize);
                1: ta[i] = base + ADDR_W'(($urandom % 8) * 256) + off;
                default: ta[i] = ADDR_W'($urandom) & ~ADDR_W'(tsize - 1);
            endcase
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(start_ready && !req_valid && !done, "R1", "reset state",
            MAXB'({start_ready, req_valid, done}), MAXB'(4));
        rst_n = 1'b1;
        @(negedge clk);
        chk(start_ready && !req_valid && !done, "R1", "idle after reset",
            MAXB'({start_ready, req_valid, done}), MAXB'(4));

        // R10: all lanes inactive
        for (int i = 0; i < LANES; i++) ta[i] = 32'h1000 + ADDR_W'(i * 64);
        tact = '0; tsize = 4; twr = 0; tsp = 2'd1;
        run_instr(100);

        // R2: zero line size space issues nothing
        tact = '1; tsp = 2'd0;
        run_instr(100);
        tsp = 2'd3;
        run_instr(100);

        // R3/R6: all lanes in one texture line
        for (int i = 0; i < LANES; i++) ta[i] = 32'h0004_0000 + ADDR_W'(i * 4);
        tact = '1; tsize = 4; twr = 1; tsp = 2'd1;
        run_instr(100);

        // R5: lanes in descending distinct constant lines
        for (int i = 0; i < LANES; i++) ta[i] = 32'h0008_0000 + ADDR_W'((LANES - 1 - i) * 64) + 8;
        tact = '1; tsize = 8; twr = 0; tsp = 2'd2;
        run_instr(100);

        // R6: access running past the line end drops the bytes beyond it
        for (int i = 0; i < LANES; i++) ta[i] = 32'h0010_0000 + ADDR_W'(i * 1024);
        ta[0] = 32'h0010_003C;
        ta[1] = 32'h0010_00C8;
        tact = 32'h3; tsize = 8; twr = 0; tsp = 2'd2;
        run_instr(100);

        // R4: odd lanes inactive with addresses in their own lines
        for (int i = 0; i < LANES; i++)
            ta[i] = (i % 2 == 0) ? 32'h0020_0000 + ADDR_W'(i * 2)
                                 : 32'h0030_0000 + ADDR_W'(i * 512);
        tact = 32'h5555_5555; tsize = 2; twr = 1; tsp = 2'd1;
        run_instr(100);

        // R8: heavy back-pressure
        for (int i = 0; i < LANES; i++) ta[i] = 32'h0040_0000 + ADDR_W'((i % 5) * 128) + ADDR_W'(i * 4 % 128);
        tact = '1; tsize = 4; twr = 0; tsp = 2'd1;
        run_instr(20);

        for (int n = 0; n < 300; n++) begin
            gen_random();
            run_instr(30 + ($urandom % 71));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule